// File: doc/BRIEF.md
# Scalable Radix-2 FFT Sequencer

This block is the control half of an in-place radix-2 decimation-in-time FFT engine. One butterfly unit is shared by every butterfly of every stage. The sample store is two memories, each half the width of a complex word: one holds the real parts and one the imaginary parts. Both memories take the same address and enables from this block, so each access moves one complex word in one cycle. The sequencer produces the read and write addresses, the twiddle-table index, the operand tags, the stage and butterfly counters and a completion pulse. The butterfly arithmetic, the memories and the twiddle contents live outside it.

A run starts with a start pulse while the block is idle. The transform size is taken from a 3-bit code at that moment. The run has three phases:

- **Load.** Samples arrive in natural order, one per cycle, and are written at bit-reversed addresses.
- **Compute.** Each of the log2(N) stages reads the two operands of each butterfly on consecutive cycles. The write port repeats every read address a fixed pipeline latency later, which is where the butterfly result returns. A stage ends with a drain of that latency before the next stage may read.
- **Unload.** The results are read in natural order.

A one-cycle done pulse then returns the block to idle.

The states are:

- IDLE waits for start. On start it goes to LOAD.
- LOAD runs N cycles. After the last sample it goes to READ.
- READ runs N cycles, two per butterfly. After the last butterfly it goes to DRAIN.
- DRAIN runs LAT cycles. It then goes to READ for the next stage, or to UNLOAD after the last stage.
- UNLOAD runs N cycles. After the last read it goes to DONE.
- DONE lasts one cycle and then goes to IDLE.

With the default latency of 2, the compute phase of a 256-point transform takes 8 × 258 = 2064 cycles.

Top module: `fft_seq_ctrl`

## Requirements
- R1: The size code is latched on an accepted start and selects N = 2^(code+3): code 0 gives 8 points and code 7 gives 1024. A later change of the code has no effect until the next run.
- R2: A start seen in IDLE moves the block to LOAD on the next cycle, with busy=1 and phase=1. A start while busy=1, including the DONE cycle, is ignored.
- R3: LOAD lasts N cycles. In load cycle k, wr_en=1 and rd_en=0. wr_addr is k with its low log2(N) bits reversed, and phase=1.
- R4: In stage s, butterfly b is read in two consecutive cycles, with butterflies taken in increasing order. The first cycle has rd_addr = ((b>>s)<<(s+1)) | (b mod 2^s) and rd_opnd=0. The second has rd_addr = that value + 2^s and rd_opnd=1. During both cycles, stage=s, bfly=b, phase=2 and rd_en=1.
- R5: During both read cycles of butterfly b in stage s, tw_addr = (b mod 2^s) << (log2(N)−1−s). It is therefore 0 throughout stage 0.
- R6: Every compute-phase read reappears on the write port exactly LAT cycles later, with wr_en=1, the same address and the same operand tag. No other compute-phase cycle has wr_en=1.
- R7: After the last read of a stage there are LAT cycles with rd_en=0 and phase=2. The next stage's first read comes in the cycle right after the write of the previous stage's last operand.
- R8: After log2(N) stages, UNLOAD lasts N cycles. In unload cycle k, rd_addr=k, rd_en=1, wr_en=0 and phase=3.
- R9: done=1 for exactly one cycle, the one after the last unload read. The block is idle (busy=0, phase=0) in the cycle after that.
- R10: While rst_n=0 and after its release, the block is idle: busy, done, rd_en and wr_en are 0 and phase is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run request, taken only in IDLE |
| size_sel | input | 3 | Transform size code, N = 2^(code+3) |
| busy | output | 1 | High from LOAD through DONE |
| phase | output | 2 | 0 idle, 1 load, 2 compute, 3 unload |
| rd_en | output | 1 | Read strobe to both half-width memories |
| rd_addr | output | 10 | Read address |
| rd_opnd | output | 1 | 0 for the upper operand of the butterfly, 1 for the lower |
| tw_addr | output | 9 | Twiddle table index |
| wr_en | output | 1 | Write strobe to both half-width memories |
| wr_addr | output | 10 | Write address (load sample or butterfly result) |
| wr_opnd | output | 1 | Operand tag of the result being written |
| stage | output | 4 | Current stage counter |
| bfly | output | 9 | Current butterfly counter |
| done | output | 1 | One-cycle completion pulse |

## Verification
During a stage, the read of a new operand and the writeback of the operand read LAT cycles earlier happen in the same cycle. The bench follows its own record of past reads and judges the write port and the read port in every compute cycle. This shows that the overlap neither drops nor shifts a write, and that the stage barrier only releases reads once the final write has gone out. A second coincidence is a start pulse that lands on the DONE cycle, or in the middle of a run together with a changed size code. The bench drives both cases. It expects the block to be idle after DONE, and it expects the in-flight run to keep its latched size, cycle by cycle.

// File: rtl/fft_seq_pkg.sv
package fft_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_READ,
        S_DRAIN,
        S_UNLOAD,
        S_DONE
    } seq_state_t;

    localparam logic [1:0] PH_IDLE    = 2'd0;
    localparam logic [1:0] PH_LOAD    = 2'd1;
    localparam logic [1:0] PH_COMPUTE = 2'd2;
    localparam logic [1:0] PH_UNLOAD  = 2'd3;

endpackage

// File: rtl/fft_seq_addr.sv
module fft_seq_addr #(
    parameter int AW  = 10,
    parameter int STW = 4
) (
    input  logic [AW-2:0]  bfly,
    input  logic [STW-1:0] stage,
    input  logic [STW-1:0] log_n,
    output logic [AW-1:0]  addr_a,
    output logic [AW-1:0]  span,
    output logic [AW-2:0]  tw
);
    logic [AW-2:0]  low_mask;
    logic [AW-2:0]  pos;
    logic [AW-2:0]  grp;
    logic [STW-1:0] tw_shift;

    always_comb begin
        low_mask = ((AW-1)'(1) << stage) - (AW-1)'(1);
        pos      = bfly & low_mask;
        grp      = bfly >> stage;
        addr_a   = ((AW'(grp) << stage) << 1) | AW'(pos);
        span     = AW'(1) << stage;
        tw_shift = log_n - STW'(1) - stage;
        tw       = pos << tw_shift;
    end
endmodule

// File: rtl/fft_seq_wbpipe.sv
module fft_seq_wbpipe #(
    parameter int W   = 11,
    parameter int LAT = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_v,
    input  logic [W-1:0] in_d,
    output logic         out_v,
    output logic [W-1:0] out_d
);
    logic         v_q [LAT];
    logic [W-1:0] d_q [LAT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) begin
                v_q[i] <= 1'b0;
                d_q[i] <= '0;
            end
        end else begin
            v_q[0] <= in_v;
            d_q[0] <= in_d;
            for (int i = 1; i < LAT; i++) begin
                v_q[i] <= v_q[i-1];
                d_q[i] <= d_q[i-1];
            end
        end
    end

    assign out_v = v_q[LAT-1];
    assign out_d = d_q[LAT-1];
endmodule

// File: rtl/fft_seq_ctrl.sv
module fft_seq_ctrl
    import fft_seq_pkg::*;
#(
    parameter  int MAX_LOG = 10,
    parameter  int MIN_LOG = 3,
    parameter  int LAT     = 2,
    localparam int AW      = MAX_LOG,
    localparam int SELW    = $clog2(MAX_LOG - MIN_LOG + 1),
    localparam int STW     = $clog2(MAX_LOG + 1),
    localparam int DCW     = (LAT > 1) ? $clog2(LAT) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [SELW-1:0] size_sel,
    output logic            busy,
    output logic [1:0]      phase,
    output logic            rd_en,
    output logic [AW-1:0]   rd_addr,
    output logic            rd_opnd,
    output logic [AW-2:0]   tw_addr,
    output logic            wr_en,
    output logic [AW-1:0]   wr_addr,
    output logic            wr_opnd,
    output logic [STW-1:0]  stage,
    output logic [AW-2:0]   bfly,
    output logic            done
);
    seq_state_t     state_q, state_d;
    logic [STW-1:0] log_q;
    logic [AW-1:0]  cnt_q;
    logic [STW-1:0] stg_q;
    logic [DCW-1:0] dcnt_q;

    logic [AW-1:0]  nmask;
    logic [AW-1:0]  rev;
    logic           cnt_last;
    logic           drain_last;
    logic           stage_last;

    logic [AW-1:0]  addr_a;
    logic [AW-1:0]  span;
    logic [AW-2:0]  tw_c;

    logic           pipe_v;
    logic [AW:0]    pipe_d;
    logic [AW-1:0]  rd_addr_c;
    logic           rd_opnd_c;
    logic           rd_cmp;

    // Helpers: size mask, bit reversal over log2(N), end-of-count flags.
    always_comb begin
        nmask = '0;
        rev   = '0;
        for (int i = 0; i < AW; i++) begin
            nmask[i] = (i < int'(log_q));
            for (int j = 0; j < AW; j++) begin
                if (i < int'(log_q) && j == int'(log_q) - 1 - i) begin
                    rev[i] = cnt_q[j];
                end
            end
        end
        cnt_last   = (cnt_q == nmask);
        drain_last = (dcnt_q == DCW'(LAT - 1));
        stage_last = (stg_q == log_q - STW'(1));
    end

    fft_seq_addr #(.AW(AW), .STW(STW)) u_addr (
        .bfly   (cnt_q[AW-1:1]),
        .stage  (stg_q),
        .log_n  (log_q),
        .addr_a (addr_a),
        .span   (span),
        .tw     (tw_c)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start)      state_d = S_LOAD;
            S_LOAD:   if (cnt_last)   state_d = S_READ;
            S_READ:   if (cnt_last)   state_d = S_DRAIN;
            S_DRAIN:  if (drain_last) state_d = stage_last ? S_UNLOAD : S_READ;
            S_UNLOAD: if (cnt_last)   state_d = S_DONE;
            S_DONE:                   state_d = S_IDLE;
            default:                  state_d = S_IDLE;
        endcase
    end

    // Counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            log_q  <= STW'(MIN_LOG);
            cnt_q  <= '0;
            stg_q  <= '0;
            dcnt_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    cnt_q <= '0;
                    stg_q <= '0;
                    if (start) log_q <= STW'(MIN_LOG) + STW'(size_sel);
                end
                S_LOAD, S_READ, S_UNLOAD: begin
                    cnt_q  <= cnt_last ? '0 : cnt_q + AW'(1);
                    dcnt_q <= '0;
                end
                S_DRAIN: begin
                    dcnt_q <= dcnt_q + DCW'(1);
                    if (drain_last && !stage_last) stg_q <= stg_q + STW'(1);
                end
                default: begin
                    cnt_q <= '0;
                end
            endcase
        end
    end

    fft_seq_wbpipe #(.W(AW + 1), .LAT(LAT)) u_wb (
        .clk   (clk),
        .rst_n (rst_n),
        .in_v  (rd_cmp),
        .in_d  ({rd_opnd_c, rd_addr_c}),
        .out_v (pipe_v),
        .out_d (pipe_d)
    );

    // Outputs
    always_comb begin
        rd_cmp    = (state_q == S_READ);
        rd_opnd_c = rd_cmp & cnt_q[0];
        rd_addr_c = '0;
        if (rd_cmp)                   rd_addr_c = addr_a + (cnt_q[0] ? span : '0);
        else if (state_q == S_UNLOAD) rd_addr_c = cnt_q;

        busy    = (state_q != S_IDLE);
        done    = (state_q == S_DONE);
        rd_en   = rd_cmp || (state_q == S_UNLOAD);
        rd_addr = rd_addr_c;
        rd_opnd = rd_opnd_c;
        tw_addr = rd_cmp ? tw_c : '0;
        stage   = stg_q;
        bfly    = rd_cmp ? cnt_q[AW-1:1] : '0;
        wr_en   = (state_q == S_LOAD) || pipe_v;
        wr_addr = (state_q == S_LOAD) ? rev : pipe_d[AW-1:0];
        wr_opnd = pipe_v & pipe_d[AW];

        unique case (state_q)
            S_LOAD:           phase = PH_LOAD;
            S_READ, S_DRAIN:  phase = PH_COMPUTE;
            S_UNLOAD:         phase = PH_UNLOAD;
            default:          phase = PH_IDLE;
        endcase
    end
endmodule

// File: rtl/fft_seq_ctrl_chk.sv
module fft_seq_ctrl_chk #(
    parameter int AW  = 10,
    parameter int STW = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic [1:0]     phase,
    input logic           rd_en,
    input logic [AW-1:0]  rd_addr,
    input logic           rd_opnd,
    input logic [AW-2:0]  tw_addr,
    input logic           wr_en,
    input logic [STW-1:0] stage,
    input logic           done
);
    // R9: single-cycle done, then idle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R2: a run only begins after a start request
    a_r2_start_begins: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R3: no reads while loading
    a_r3_load_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd1) |-> (wr_en && !rd_en));

    // R4: the lower operand is one span above the upper operand
    a_r4_operand_span: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_opnd && phase == 2'd2)
            |-> (rd_addr == $past(rd_addr) + (AW'(1) << stage)));

    // R5: the first stage uses only twiddle index zero
    a_r5_tw_stage0: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && phase == 2'd2 && stage == '0) |-> (tw_addr == '0));

    // R8: no writes while unloading
    a_r8_unload_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd3) |-> (rd_en && !wr_en));
endmodule

bind fft_seq_ctrl fft_seq_ctrl_chk #(.AW(AW), .STW(STW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .phase   (phase),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_opnd (rd_opnd),
    .tw_addr (tw_addr),
    .wr_en   (wr_en),
    .stage   (stage),
    .done    (done)
);

// File: tb/tb_fft_seq_ctrl.sv
module tb_fft_seq_ctrl;
    localparam int LAT = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] size_sel = 3'd0;
    logic       busy, rd_en, rd_opnd, wr_en, wr_opnd, done;
    logic [1:0] phase;
    logic [9:0] rd_addr, wr_addr;
    logic [8:0] tw_addr, bfly;
    logic [3:0] stage;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    fft_seq_ctrl #(.MAX_LOG(10), .MIN_LOG(3), .LAT(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .size_sel(size_sel),
        .busy(busy), .phase(phase), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_opnd(rd_opnd), .tw_addr(tw_addr), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_opnd(wr_opnd), .stage(stage),
        .bfly(bfly), .done(done)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int brev(int v, int nb);
        int r = 0;
        for (int i = 0; i < nb; i++) r |= ((v >> i) & 1) << (nb - 1 - i);
        return r;
    endfunction

    task automatic test_reset();
        start = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 busy in reset", busy, 0);
        chk("R10 phase in reset", phase, 0);
        chk("R10 rd_en in reset", rd_en, 0);
        chk("R10 wr_en in reset", wr_en, 0);
        chk("R10 done in reset", done, 0);
        start = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 busy after release", busy, 0);
        chk("R10 phase after release", phase, 0);
    endtask

    // One full run; poke>0 injects a start with another size code mid-run.
    task automatic run_fft(int sel, int poke, bit start_at_done);
        int nb = sel + 3;
        int n  = 1 << nb;
        int wv[LAT];
        int wa[LAT];
        int wo[LAT];
        for (int i = 0; i < LAT; i++) begin wv[i] = 0; wa[i] = 0; wo[i] = 0; end

        @(negedge clk);
        size_sel = 3'(sel);
        start = 1'b1;
        if (poke > 0) begin
            fork
                begin
                    repeat (poke) @(negedge clk);
                    start = 1'b1;
                    size_sel = 3'(sel ^ 7);
                    @(negedge clk);
                    start = 1'b0;
                end
            join_none
        end
        @(negedge clk);
        start = 1'b0;

        // load
        for (int k = 0; k < n; k++) begin
            chk("R2 busy in load", busy, 1);
            chk("R3 phase", phase, 1);
            chk("R3 wr_en", wr_en, 1);
            chk("R3 rd_en", rd_en, 0);
            chk("R3 wr_addr bitrev", wr_addr, brev(k, nb));
            @(negedge clk);
        end

        // compute
        for (int s = 0; s < nb; s++) begin
            for (int b = 0; b < n / 2; b++) begin
                for (int ph = 0; ph < 2; ph++) begin
                    int pos = b & ((1 << s) - 1);
                    int a = (((b >> s) << (s + 1)) | pos) + ph * (1 << s);
                    chk("R4 rd_en", rd_en, 1);
                    chk("R4 phase", phase, 2);
                    chk("R4 rd_addr", rd_addr, a);
                    chk("R4 rd_opnd", rd_opnd, ph);
                    chk("R4 stage", stage, s);
                    chk("R4 bfly", bfly, b);
                    chk("R5 tw_addr", tw_addr, pos << (nb - 1 - s));
                    chk("R6 wr_en", wr_en, wv[LAT-1]);
                    if (wv[LAT-1] != 0) begin
                        chk("R6 wr_addr", wr_addr, wa[LAT-1]);
                        chk("R6 wr_opnd", wr_opnd, wo[LAT-1]);
                    end
                    for (int i = LAT - 1; i > 0; i--) begin
                        wv[i] = wv[i-1]; wa[i] = wa[i-1]; wo[i] = wo[i-1];
                    end
                    wv[0] = 1; wa[0] = a; wo[0] = ph;
                    @(negedge clk);
                end
            end
            for (int d = 0; d < LAT; d++) begin
                chk("R7 no read in drain", rd_en, 0);
                chk("R7 phase in drain", phase, 2);
                chk("R6 wr_en in drain", wr_en, wv[LAT-1]);
                if (wv[LAT-1] != 0) begin
                    chk("R6 wr_addr in drain", wr_addr, wa[LAT-1]);
                    chk("R6 wr_opnd in drain", wr_opnd, wo[LAT-1]);
                end
                for (int i = LAT - 1; i > 0; i--) begin
                    wv[i] = wv[i-1]; wa[i] = wa[i-1]; wo[i] = wo[i-1];
                end
                wv[0] = 0; wa[0] = 0; wo[0] = 0;
                @(negedge clk);
            end
        end

        // unload
        for (int k = 0; k < n; k++) begin
            chk("R8 phase", phase, 3);
            chk("R8 rd_en", rd_en, 1);
            chk("R8 rd_addr natural", rd_addr, k);
            chk("R8 wr_en", wr_en, 0);
            @(negedge clk);
        end

        chk("R1 R9 done after run of latched size", done, 1);
        chk("R9 busy during done", busy, 1);
        if (start_at_done) start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9 done falls", done, 0);
        chk("R2 R9 idle after done", busy, 0);
        chk("R9 phase idle", phase, 0);
        @(negedge clk);
        chk("R2 start on done ignored", busy, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        test_reset();
        run_fft(0, 20, 1'b0);   // R1: mid-run start and size change ignored
        run_fft(1, 0, 1'b1);    // R2: start during DONE ignored
        run_fft(5, 0, 1'b0);    // 256 points
        run_fft(7, 0, 1'b0);    // 1024 points
        run_fft(2, 0, 1'b0);    // 32 points after a large run
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule